// File: doc/BRIEF.md
# Reloading Byte Timer with Square-Wave Output

This block is an 8-bit up-counter that reloads itself. Each time the count passes its top value it loads a stored reload byte and raises a sticky overflow flag. It can also drive a square wave on a dedicated output. The output toggles on every overflow, so the wave has a frequency of source / (256 - reload) / 2. The count source is chosen by a control word. It can be the system clock on every cycle, one cycle in twelve, or falling edges seen on an external count pin.

Software-style writes load the reload byte and the control word. A run enable starts and stops counting, and a clear strobe drops the overflow flag. A new reload value only takes effect at the next overflow. This means a running wave never sees a period that is cut short.

Counting is governed by a two-state machine. In `ST_HALT` the count and the output hold still. The transition `ST_HALT -> ST_RUN` is taken when the run enable is seen high. In `ST_RUN` the counter advances on each source tick. The transition `ST_RUN -> ST_HALT` is taken when the run enable is seen low.

Top module: `reload_clkout_timer`

## Requirements
- R1: After reset, clk_out and ovf_flag are 0, and both the count and the reload byte are 0.
- R2: With the fast source (ctrl_wdata[2]=1, ctrl_wdata[1]=0), the counter advances once per clock. Between overflows there are 256 - reload cycles, and the same gap separates toggles of clk_out.
- R3: With the divided source (ctrl_wdata[2]=0, ctrl_wdata[1]=0), the counter advances once per 12 clocks. The gap between toggles is 12 x (256 - reload) cycles.
- R4: With the external source (ctrl_wdata[1]=1, which overrides bit 2), each falling edge of ext_cnt_in advances the counter once. The edge is detected after a two-flop synchroniser. With a pin period of P clocks, toggles are P x (256 - reload) cycles apart.
- R5: A reload value of 255 gives an overflow on every count enable. In fast mode, clk_out then toggles every clock.
- R6: A write to the reload byte does not disturb the period in progress. It is loaded into the counter at the next overflow.
- R7: With clock-out disabled (ctrl_wdata[0]=0), clk_out stays 0. Overflows still set ovf_flag.
- R8: ovf_flag is sticky and is set by every overflow. A pulse on ovf_clr clears it. If an overflow and a clear arrive in the same cycle, the set wins.
- R9: While run_en is low, the count, the prescaler phase and clk_out all hold. The divide-by-12 phase restarts from zero when run_en goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_we | input | 1 | Write strobe for the reload byte |
| reload_wdata | input | 8 | New reload byte |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 3 | Control word: bit 0 clock-out enable, bit 1 external source, bit 2 fast source |
| run_en | input | 1 | Count enable |
| ext_cnt_in | input | 1 | External count pin (asynchronous) |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| clk_out | output | 1 | Square-wave output, toggled per overflow |

## Verification
The bench builds the block with its defaults: an 8-bit count, a divide-by-12 prescaler and a two-stage synchroniser.

Reload values near the top of the range shorten each period to a few cycles. With these, the bench can measure the exact toggle gap in all three source modes within a short run. The shortest case, a reload of 255, gives a toggle on every clock.

A reload change is written just after a toggle. The bench then confirms that the old gap is seen once more before the new one appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    typedef struct packed {
        logic clkout_en;
        src_e src;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t decode_ctrl(input logic [2:0] w);
        tmr_ctrl_t c;
        c.clkout_en = w[0];
        if (w[1])      c.src = SRC_EXT;
        else if (w[2]) c.src = SRC_FAST;
        else           c.src = SRC_DIV;
        return c;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (!run_en)        phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign tick = run_en && (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: the divided tick is a single-cycle pulse
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

    // R9: the phase is cleared while the run enable is low
    p_phase_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (phase_q == '0));
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] sync_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SW-2:0], pin};
            prev_q <= sync_q[SW-1];
        end
    end

    assign fall = prev_q && !sync_q[SW-1];

    // R4: at most one count per detected edge
    p_single_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic         clkout_en,
    input  logic [W-1:0] reload,
    output logic         ovf_pulse,
    output logic         clk_out
);
    run_st_e      st_q, st_d;
    logic [W-1:0] cnt_q;
    logic         adv;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (run_en)  st_d = ST_RUN;
            ST_RUN:  if (!run_en) st_d = ST_HALT;
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    assign adv       = (st_q == ST_RUN) && run_en && tick;
    assign ovf_pulse = adv && (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clk_out <= 1'b0;
        end else begin
            if (ovf_pulse)  cnt_q <= reload;
            else if (adv)   cnt_q <= cnt_q + 1'b1;
            if (!clkout_en) clk_out <= 1'b0;
            else if (ovf_pulse) clk_out <= !clk_out;
        end
    end

    // R6: an overflow loads the reload byte held at that edge
    p_reload_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (cnt_q == $past(reload)));
    // R7: disabled clock-out is held low
    p_clkout_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clkout_en |=> !clk_out);
    // R9: no count movement while halted
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cnt_q));
    // R5: an all-ones reload overflows on the very next advance
    p_top_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == '1 && reload == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/reload_clkout_timer.sv
module reload_clkout_timer
    import tmr_pkg::*;
#(
    parameter int COUNT_W     = 8,
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload_we,
    input  logic [COUNT_W-1:0] reload_wdata,
    input  logic               ctrl_we,
    input  logic [2:0]         ctrl_wdata,
    input  logic               run_en,
    input  logic               ext_cnt_in,
    input  logic               ovf_clr,
    output logic               ovf_flag,
    output logic               clk_out
);
    logic [COUNT_W-1:0] reload_q;
    tmr_ctrl_t          ctrl_q;
    logic               pre_tick, ext_fall, src_tick, ovf_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '{clkout_en: 1'b0, src: SRC_DIV};
        end else begin
            if (reload_we) reload_q <= reload_wdata;
            if (ctrl_we)   ctrl_q   <= decode_ctrl(ctrl_wdata);
        end
    end

    tmr_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(pre_tick)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_cnt_in), .fall(ext_fall)
    );

    always_comb begin
        unique case (ctrl_q.src)
            SRC_FAST: src_tick = 1'b1;
            SRC_EXT:  src_tick = ext_fall;
            default:  src_tick = pre_tick;
        endcase
    end

    tmr_core #(.W(COUNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(src_tick),
        .clkout_en(ctrl_q.clkout_en), .reload(reload_q),
        .ovf_pulse(ovf_pulse), .clk_out(clk_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (ovf_pulse) ovf_flag <= 1'b1;
        else if (ovf_clr)   ovf_flag <= 1'b0;
    end

    // R8: every overflow leaves the flag set, even against a clear
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> ovf_flag);
    // R8: a clear without an overflow drops the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_pulse) |=> !ovf_flag);
    // R2: clk_out only moves on an overflow or a disable
    p_toggle_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_pulse && ctrl_q.clkout_en) |=> $stable(clk_out));
endmodule

// File: tb/test_reload_clkout_timer.sv
module test_reload_clkout_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload_we = 1'b0;
    logic [7:0] reload_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic       run_en = 1'b0;
    logic       ext_cnt_in = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag, clk_out;

    always #4 clk = ~clk;

    reload_clkout_timer i_reload_clkout_timer (
        .clk(clk), .rst_n(rst_n), .reload_we(reload_we), .reload_wdata(reload_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .run_en(run_en),
        .ext_cnt_in(ext_cnt_in), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .clk_out(clk_out)
    );

    int    n_vec = 0, n_bad = 0, cyc = 0, last_t = 0, toggle_cnt = 0, pending = 0;
    logic  last_out = 1'b0;
    bit    done = 0, ext_gen = 0;
    int    exp_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures gaps between clk_out toggles and compares them
    always @(negedge clk) begin
        if (clk_out !== last_out) begin
            last_out = clk_out;
            if (exp_q.size() > 0) begin
                chk(tag_q.pop_front(), cyc - last_t, exp_q.pop_front());
                pending--;
            end
            last_t = cyc;
            toggle_cnt++;
        end
    end

    // external pin generator: period of 4 clocks
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (ext_gen) begin
                ph++;
                ext_cnt_in = ph[1];
            end
        end
    end

    task automatic push(input string req, input int gap, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(gap);
            tag_q.push_back(req);
            pending++;
        end
    endtask

    task automatic wait_toggles(input int n);
        int t0 = toggle_cnt;
        wait (toggle_cnt >= t0 + n);
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    task automatic wr_reload(input logic [7:0] v);
        reload_wdata = v; reload_we = 1'b1;
        @(negedge clk); reload_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        ctrl_wdata = v; ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int base;
        logic held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 clk_out", clk_out, 0);
        chk("R1 ovf_flag", ovf_flag, 0);

        // R2: fast source, reload 250 -> gap 6
        wr_ctrl(3'b101);
        wr_reload(8'd250);
        run_en = 1'b1;
        wait_toggles(2);
        push("R2", 6, 4);
        drain();

        // R5: reload 255 -> toggle every clock
        wr_reload(8'd255);
        wait_toggles(2);
        push("R5", 1, 4);
        drain();

        // R6: reload change mid-period keeps the running gap once
        wr_reload(8'd250);
        wait_toggles(3);
        push("R6", 6, 1);
        push("R6", 56, 2);
        wr_reload(8'd200);
        drain();

        // R3: divided source, reload 252 -> gap 48
        wr_ctrl(3'b001);
        wr_reload(8'd252);
        wait_toggles(2);
        push("R3", 48, 3);
        drain();

        // R4: external source with fast bit also set (ext wins), reload 253, pin period 4 -> gap 12
        ext_gen = 1;
        wr_ctrl(3'b111);
        wr_reload(8'd253);
        wait_toggles(2);
        push("R4", 12, 3);
        drain();
        ext_gen = 0;

        // R7: clock-out disabled, overflows still flag
        wr_ctrl(3'b100);
        wr_reload(8'd250);
        pulse_clr();
        base = toggle_cnt;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_out !== 1'b0) chk("R7 clk_out low", clk_out, 0);
        end
        chk("R7 clk_out", clk_out, 0);
        chk("R7 flag set", ovf_flag, 1);

        // R8: clear strobe drops the sticky flag once stopped
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 flag before clear", ovf_flag, 1);
        pulse_clr();
        chk("R8 flag cleared", ovf_flag, 0);

        // R9: halted -> nothing moves
        wr_ctrl(3'b101);
        repeat (2) @(negedge clk);
        held = clk_out;
        base = toggle_cnt;
        repeat (300) @(negedge clk);
        chk("R9 clk_out held", clk_out, held);
        chk("R9 no toggles", toggle_cnt - base, 0);
        chk("R9 flag quiet", ovf_flag, 0);
        run_en = 1'b1;
        wait_toggles(2);
        push("R9 resume", 6, 2);
        drain();
        chk("R9 flag after resume", ovf_flag, 1);

        finish_run();
    end
endmodule